// File: doc/BRIEF.md
# Shift-Register Dual Stack Unit

This block holds the two stacks of a small stack processor: a data stack and a return stack. Neither stack uses a memory array or a pointer. Each stack is a chain of registers, and every entry moves one place on each push or pop. The data stack is a top register T with a 17-entry shift bank behind it, which gives 18 elements in all. The return stack is its own 17-entry bank. The value at the head of that bank, R0, is brought out so that it can serve as a memory address. T can serve as the holding register for memory data.

Each stack has its own push and pop strobes, and both stacks share one write-value input. Two transfer strobes move a word from T onto the return stack, or from R0 onto the data stack. Both actions happen in one clock. When a bank is full, a push silently drops the deepest word. When a stack is popped, its deepest word stays in place, so the bottom value is repeated upward. No error flag is raised in either case. All outputs are registered, and every operation completes on the clock edge that samples it.

Top module: `twin_stack_unit`

## Requirements
- R1: A synchronous active-high reset sets every entry of both stacks to zero, so T, S0 and R0 read as 0 on the edge after reset. Every entry is 21 bits wide.
- R2: A data push (push strobe only) loads the write value into T, moves the old T into S0, and moves each S(i) into S(i+1).
- R3: A data pop (pop strobe only) moves S0 into T and each S(i+1) into S(i).
- R4: On a pop of either stack, the deepest entry of the bank keeps its value. After enough pops, every element of that stack holds the old bottom value.
- R5: Overflow is silent. When a push is made with all 18 data elements (or all 17 return elements) in use, the deepest word is discarded.
- R6: Push and pop asserted together on the same stack replace the top element (T, or R0) with the write value and shift nothing.
- R7: A return push loads the write value into R0 and shifts the bank down. A return pop shifts the bank up.
- R8: The to-return strobe alone moves T onto the return stack (R0 gets the old T) and pops the data stack (T gets S0), all in one cycle.
- R9: The from-return strobe alone moves R0 onto the data stack (T gets the old R0, S0 gets the old T) and pops the return stack, all in one cycle.
- R10: Both transfer strobes together swap T and R0 and shift neither bank. Whenever either transfer strobe is high, the four push and pop strobes are ignored.
- R11: The two stacks are not chained. Operations on one stack leave the other stack's visible entries unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ds_push | input | 1 | Push onto the data stack |
| ds_pop | input | 1 | Pop the data stack |
| rs_push | input | 1 | Push onto the return stack |
| rs_pop | input | 1 | Pop the return stack |
| to_rs | input | 1 | Move T onto the return stack |
| from_rs | input | 1 | Move R0 onto the data stack |
| wr_data | input | 21 | Value written by push or replace |
| t_out | output | 21 | Top of data stack (T) |
| s0_out | output | 21 | Second data element (S0) |
| r0_out | output | 21 | Top of return stack (R0) |

## Verification
Every operation's effect on T, S0 and R0 appears one clock edge after the strobes are sampled. The bench therefore changes the strobes on a falling edge and compares all three outputs on the next falling edge, once the intervening rising edge has updated them. Effects that reach deeper into a bank, such as overflow loss and bottom replication, cannot be seen directly. The bench brings them out by popping the stack repeatedly and checking each value as it surfaces at T or R0, one pop per cycle. A sweep over every combination of the six strobes is checked against an 18-plus-17-entry model held in the bench.

// File: rtl/twin_stack_pkg.sv
package twin_stack_pkg;

    localparam int WORD_W  = 21;
    localparam int DS_BANK = 17;
    localparam int RS_BANK = 17;

    typedef enum logic [1:0] {
        BK_HOLD,
        BK_PUSH,
        BK_POP,
        BK_REPL
    } bank_op_e;

    typedef enum logic [1:0] {
        TS_HOLD,
        TS_WR,
        TS_FROM_S0,
        TS_FROM_R0
    } tsrc_e;

    typedef struct packed {
        tsrc_e    t_src;
        bank_op_e s_op;
        bank_op_e r_op;
        logic     r_from_t;
    } stk_ctrl_t;

    function automatic logic any_transfer(input logic to_r, input logic from_r);
        return to_r | from_r;
    endfunction

endpackage

// File: rtl/shift_bank.sv
module shift_bank
    import twin_stack_pkg::*;
#(
    parameter int W     = 21,
    parameter int DEPTH = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  bank_op_e     op,
    input  logic [W-1:0] head_in,
    output logic [W-1:0] head_out
);

    localparam int LAST = DEPTH - 1;

    logic [W-1:0] ent [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) begin
                    ent[i] <= '0;
                end else begin
                    case (op)
                        BK_PUSH: ent[i] <= head_in;
                        BK_REPL: ent[i] <= head_in;
                        BK_POP:  ent[i] <= (LAST > 0) ? ent[(LAST > 0) ? 1 : 0] : ent[i];
                        default: ent[i] <= ent[i];
                    endcase
                end
            end
        end else if (i == LAST) begin : g_tail
            always_ff @(posedge clk) begin
                if (rst) begin
                    ent[i] <= '0;
                end else if (op == BK_PUSH) begin
                    ent[i] <= ent[i-1];
                end
            end
        end else begin : g_mid
            always_ff @(posedge clk) begin
                if (rst) begin
                    ent[i] <= '0;
                end else begin
                    case (op)
                        BK_PUSH: ent[i] <= ent[i-1];
                        BK_POP:  ent[i] <= ent[i+1];
                        default: ent[i] <= ent[i];
                    endcase
                end
            end
        end
    end

    assign head_out = ent[0];

    // R4: the deepest cell is never refilled from below on a pop
    assert_bottom_kept_R4: assert property (@(posedge clk) disable iff (rst)
        (op == BK_POP) |=> (ent[LAST] == $past(ent[LAST])));

    // R5: the deepest cell takes its neighbour's value on a push, old tail is lost
    assert_tail_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (op == BK_PUSH && DEPTH > 1) |=> (ent[LAST] == $past(ent[(LAST > 0) ? LAST-1 : 0])));

    // R2 / R7: the head takes the incoming word on push or replace
    assert_head_load_R7: assert property (@(posedge clk) disable iff (rst)
        (op == BK_PUSH || op == BK_REPL) |=> (head_out == $past(head_in)));

endmodule

// File: rtl/stack_ctrl.sv
module stack_ctrl
    import twin_stack_pkg::*;
(
    input  logic      ds_push,
    input  logic      ds_pop,
    input  logic      rs_push,
    input  logic      rs_pop,
    input  logic      to_rs,
    input  logic      from_rs,
    output stk_ctrl_t ctrl
);

    always_comb begin
        ctrl = '{t_src: TS_HOLD, s_op: BK_HOLD, r_op: BK_HOLD, r_from_t: 1'b0};
        if (any_transfer(to_rs, from_rs)) begin
            ctrl.r_from_t = 1'b1;
            if (to_rs && from_rs) begin
                ctrl.t_src = TS_FROM_R0;
                ctrl.r_op  = BK_REPL;
            end else if (to_rs) begin
                ctrl.t_src = TS_FROM_S0;
                ctrl.s_op  = BK_POP;
                ctrl.r_op  = BK_PUSH;
            end else begin
                ctrl.t_src = TS_FROM_R0;
                ctrl.s_op  = BK_PUSH;
                ctrl.r_op  = BK_POP;
            end
        end else begin
            case ({ds_push, ds_pop})
                2'b11:   ctrl.t_src = TS_WR;
                2'b10: begin
                    ctrl.t_src = TS_WR;
                    ctrl.s_op  = BK_PUSH;
                end
                2'b01: begin
                    ctrl.t_src = TS_FROM_S0;
                    ctrl.s_op  = BK_POP;
                end
                default: ctrl.t_src = TS_HOLD;
            endcase
            case ({rs_push, rs_pop})
                2'b11:   ctrl.r_op = BK_REPL;
                2'b10:   ctrl.r_op = BK_PUSH;
                2'b01:   ctrl.r_op = BK_POP;
                default: ctrl.r_op = BK_HOLD;
            endcase
        end
    end

endmodule

// File: rtl/twin_stack_unit.sv
module twin_stack_unit
    import twin_stack_pkg::*;
#(
    parameter int WIDTH   = twin_stack_pkg::WORD_W,
    parameter int S_DEPTH = twin_stack_pkg::DS_BANK,
    parameter int R_DEPTH = twin_stack_pkg::RS_BANK
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ds_push,
    input  logic             ds_pop,
    input  logic             rs_push,
    input  logic             rs_pop,
    input  logic             to_rs,
    input  logic             from_rs,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] t_out,
    output logic [WIDTH-1:0] s0_out,
    output logic [WIDTH-1:0] r0_out
);

    stk_ctrl_t        ctrl;
    logic [WIDTH-1:0] t_q;
    logic [WIDTH-1:0] r_head_in;

    stack_ctrl u_ctrl (
        .ds_push (ds_push),
        .ds_pop  (ds_pop),
        .rs_push (rs_push),
        .rs_pop  (rs_pop),
        .to_rs   (to_rs),
        .from_rs (from_rs),
        .ctrl    (ctrl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q <= '0;
        end else begin
            case (ctrl.t_src)
                TS_WR:      t_q <= wr_data;
                TS_FROM_S0: t_q <= s0_out;
                TS_FROM_R0: t_q <= r0_out;
                default:    t_q <= t_q;
            endcase
        end
    end

    assign r_head_in = ctrl.r_from_t ? t_q : wr_data;

    shift_bank #(.W(WIDTH), .DEPTH(S_DEPTH)) u_sbank (
        .clk      (clk),
        .rst      (rst),
        .op       (ctrl.s_op),
        .head_in  (t_q),
        .head_out (s0_out)
    );

    shift_bank #(.W(WIDTH), .DEPTH(R_DEPTH)) u_rbank (
        .clk      (clk),
        .rst      (rst),
        .op       (ctrl.r_op),
        .head_in  (r_head_in),
        .head_out (r0_out)
    );

    assign t_out = t_q;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (t_out == '0 && s0_out == '0 && r0_out == '0));

    assert_push_moves_t_R2: assert property (@(posedge clk) disable iff (rst)
        (ds_push && !ds_pop && !to_rs && !from_rs)
        |=> (t_out == $past(wr_data) && s0_out == $past(t_out)));

    assert_replace_top_R6: assert property (@(posedge clk) disable iff (rst)
        (ds_push && ds_pop && !to_rs && !from_rs)
        |=> (t_out == $past(wr_data) && s0_out == $past(s0_out)));

    assert_to_return_R8: assert property (@(posedge clk) disable iff (rst)
        (to_rs && !from_rs) |=> (r0_out == $past(t_out) && t_out == $past(s0_out)));

    assert_from_return_R9: assert property (@(posedge clk) disable iff (rst)
        (from_rs && !to_rs) |=> (t_out == $past(r0_out) && s0_out == $past(t_out)));

    assert_swap_R10: assert property (@(posedge clk) disable iff (rst)
        (from_rs && to_rs)
        |=> (t_out == $past(r0_out) && r0_out == $past(t_out) && $stable(s0_out)));

    assert_rs_isolated_R11: assert property (@(posedge clk) disable iff (rst)
        (!rs_push && !rs_pop && !to_rs && !from_rs) |=> $stable(r0_out));

    assert_ds_isolated_R11: assert property (@(posedge clk) disable iff (rst)
        (!ds_push && !ds_pop && !to_rs && !from_rs) |=> ($stable(t_out) && $stable(s0_out)));

endmodule

// File: tb/test_twin_stack_unit.sv
module test_twin_stack_unit;

    localparam int W  = 21;
    localparam int SD = 17;
    localparam int RD = 17;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ds_push = 0, ds_pop = 0, rs_push = 0, rs_pop = 0, to_rs = 0, from_rs = 0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] t_out, s0_out, r0_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [W-1:0] mT;
    logic [W-1:0] mS [SD];
    logic [W-1:0] mR [RD];

    always #4 clk = ~clk;

    twin_stack_unit i_twin_stack_unit (
        .clk(clk), .rst(rst),
        .ds_push(ds_push), .ds_pop(ds_pop), .rs_push(rs_push), .rs_pop(rs_pop),
        .to_rs(to_rs), .from_rs(from_rs), .wr_data(wr_data),
        .t_out(t_out), .s0_out(s0_out), .r0_out(r0_out)
    );

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void m_dpush(input logic [W-1:0] v);
        for (int i = SD-1; i > 0; i--) mS[i] = mS[i-1];
        mS[0] = mT;
        mT = v;
    endfunction

    function automatic logic [W-1:0] m_dpop();
        logic [W-1:0] old = mT;
        mT = mS[0];
        for (int i = 0; i < SD-1; i++) mS[i] = mS[i+1];
        return old;
    endfunction

    function automatic void m_rpush(input logic [W-1:0] v);
        for (int i = RD-1; i > 0; i--) mR[i] = mR[i-1];
        mR[0] = v;
    endfunction

    function automatic logic [W-1:0] m_rpop();
        logic [W-1:0] old = mR[0];
        for (int i = 0; i < RD-1; i++) mR[i] = mR[i+1];
        return old;
    endfunction

    function automatic void m_clear();
        mT = '0;
        for (int i = 0; i < SD; i++) mS[i] = '0;
        for (int i = 0; i < RD; i++) mR[i] = '0;
    endfunction

    // apply one strobe set, update the model, compare one cycle later
    task automatic op(input logic [5:0] s, input logic [W-1:0] v, input string req);
        logic [W-1:0] tmp, tmp2;
        {ds_push, ds_pop, rs_push, rs_pop, to_rs, from_rs} = s;
        wr_data = v;
        if (s[1] && s[0]) begin
            tmp = mT; mT = mR[0]; mR[0] = tmp;
        end else if (s[1]) begin
            tmp = m_dpop(); m_rpush(tmp);
        end else if (s[0]) begin
            tmp2 = m_rpop(); m_dpush(tmp2);
        end else begin
            if (s[5] && s[4]) mT = v;
            else if (s[5]) m_dpush(v);
            else if (s[4]) tmp = m_dpop();
            if (s[3] && s[2]) mR[0] = v;
            else if (s[3]) m_rpush(v);
            else if (s[2]) tmp = m_rpop();
        end
        @(negedge clk);
        {ds_push, ds_pop, rs_push, rs_pop, to_rs, from_rs} = '0;
        chk(req, "T",  t_out,  mT);
        chk(req, "S0", s0_out, mS[0]);
        chk(req, "R0", r0_out, mR[0]);
    endtask

    initial begin
        m_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1", "T after reset",  t_out,  '0);
        chk("R1", "S0 after reset", s0_out, '0);
        chk("R1", "R0 after reset", r0_out, '0);

        // R2 / R5: twenty data pushes, values 101..120; the two oldest fall off
        for (int k = 1; k <= 20; k++) op(6'b100000, W'(100 + k), "R2");
        chk("R2", "T top after fill", t_out, W'(120));
        chk("R2", "S0 after fill",    s0_out, W'(119));
        chk("R11", "R0 untouched by data ops", r0_out, '0);

        // R3 / R4 / R5: pops surface 119..103, then 103 repeats
        for (int n = 1; n <= 20; n++) begin
            op(6'b010000, '0, "R3");
            chk(n <= 17 ? "R3" : "R4", "T during drain", t_out,
                W'(n <= 17 ? 120 - n : 103));
        end
        chk("R5", "deepest survivor is third push", t_out, W'(103));

        // R7 / R5 / R4: return stack fill with 201..219 then drain
        for (int k = 1; k <= 19; k++) op(6'b001000, W'(200 + k), "R7");
        chk("R7", "R0 after fill", r0_out, W'(219));
        for (int n = 1; n <= 19; n++) begin
            op(6'b000100, '0, "R7");
            chk(n <= 16 ? "R7" : "R4", "R0 during drain", r0_out,
                W'(n <= 16 ? 219 - n : 203));
        end
        chk("R11", "T untouched by return ops", t_out, W'(103));

        // R6: replace tops
        op(6'b110000, W'(7777), "R6");
        chk("R6", "T replaced", t_out, W'(7777));
        op(6'b001100, W'(5555), "R6");
        chk("R6", "R0 replaced", r0_out, W'(5555));

        // R8 / R9 / R10 directed
        op(6'b100000, W'(42), "R2");
        op(6'b000010, '0, "R8");
        chk("R8", "R0 got T", r0_out, W'(42));
        chk("R8", "T got S0", t_out, W'(7777));
        op(6'b000001, '0, "R9");
        chk("R9", "T got R0", t_out, W'(42));
        chk("R9", "S0 got T", s0_out, W'(7777));
        op(6'b111111, W'(999), "R10");
        chk("R10", "swap T", t_out, W'(5555));
        chk("R10", "swap R0", r0_out, W'(42));

        // full sweep of all strobe combinations, several rounds
        for (int rnd = 0; rnd < 4; rnd++)
            for (int c = 0; c < 64; c++)
                op(6'(c), W'((rnd * 64 + c) * 4099 + 17),
                   (c[1] | c[0]) ? "R10" : "R11");

        // R1 again: reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_clear();
        chk("R1", "T after second reset",  t_out,  '0);
        chk("R1", "S0 after second reset", s0_out, '0);
        chk("R1", "R0 after second reset", r0_out, '0);
        for (int n = 0; n < 3; n++) op(6'b010100, '0, "R1");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule